// File: doc/BRIEF.md
# IR Transmit Carrier Modulator

This block drives an infrared emitter from a queue of timed symbols. Each symbol is a duration word together with a level bit. The level bit says whether the symbol is a mark or a space. Software-side logic pushes symbols into a small on-chip queue. The block pops them one after another with no gap between them. It holds each one for a length measured in ticks of a divided clock.

During a symbol the output either follows the level directly, or gates a square carrier. The carrier period is sixteen ticks and its high time is set by a 4-bit duty code. A polarity control selects which of the two levels carries the carrier burst.

A service-request output tells the surrounding logic when the queue needs refilling. The refill point is selectable: half empty or fully empty. A busy output shows that a symbol is being emitted. Dropping the enable input silences the emitter at once and discards every queued symbol.

Top module: `ir_tx_modulator`

## Requirements
- R1: One tick lasts `div + 1` clock cycles. A symbol with duration word `c` lasts `4*c + 3` ticks, so `busy` stays high for `(4*c + 3) * (div + 1)` cycles per symbol.
- R2: The carrier phase counts ticks modulo 16 and restarts at 0 when each symbol starts. The carrier is high while the phase is at most `duty`, which gives `duty + 1` high ticks out of 16.
- R3: With modulation on and `pol_inv = 0`, a mark (level 1) emits the carrier and a space (level 0) keeps `ir_out` low. With `pol_inv = 1` the space emits the carrier and the mark stays low.
- R4: With modulation off, `ir_out` equals the symbol level for the whole symbol, and `pol_inv` has no effect.
- R5: Queued symbols are emitted in write order and back to back. The next symbol starts on the clock edge where the previous one ends, so `busy` never drops between them.
- R6: The queue holds 8 symbols. A write while the queue is full is dropped, and the queued symbols are left unchanged.
- R7: With `wm_empty = 0`, `svc_req` is high when 4 or fewer symbols are queued. With `wm_empty = 1`, `svc_req` is high only when the queue is empty.
- R8: When no symbol is being emitted, `busy` is 0 and `ir_out` is 0.
- R9: When `tx_en` is 0, the block stops emitting on the next clock edge and empties the queue. Writes made while `tx_en` is 0 are discarded.
- R10: After reset, `busy` and `ir_out` are 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the reference for the tick divider |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; 0 halts output and flushes the queue |
| wr_en | input | 1 | Push one symbol into the queue |
| wr_count | input | 16 | Duration word of the pushed symbol |
| wr_level | input | 1 | Level of the pushed symbol (1 = mark) |
| div | input | 16 | Tick divider; a tick is div+1 cycles |
| duty | input | 4 | Carrier duty code; high for duty+1 of 16 ticks |
| mod_en | input | 1 | 1 = gate a carrier, 0 = drive the level directly |
| pol_inv | input | 1 | 1 = the carrier burst goes on spaces instead of marks |
| wm_empty | input | 1 | Service-request threshold: 1 = empty, 0 = half empty |
| ir_out | output | 1 | Emitter drive |
| busy | output | 1 | High while a symbol is being emitted |
| svc_req | output | 1 | Queue refill request |

## Verification
Single symbols are run across divider values, duty codes, both levels, both polarities and both modulation settings. For each run the bench counts busy cycles and output-high cycles. The busy count separates divider and duration errors from carrier errors. The high count separates duty errors, phase-restart errors and polarity swaps, because each of these changes the count in a different way. Queued runs add more checks. A mixed mark/space queue with modulation off shows symbol order and gapless chaining as an exact bit pattern. An overfilled queue shows the dropped write through the total busy time and is also used to sample the two refill thresholds. Disable tests show that output stops and that both queued symbols and writes made while disabled are discarded.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Carrier is high for the first duty+1 phases of each 16-phase period.
  function automatic logic carrier_on(input int phase, input int duty);
    return phase <= duty;
  endfunction

  // Refill request: only when empty, or when half or more of the slots are free.
  function automatic logic svc_needed(input int fill, input int depth, input logic only_empty);
    if (only_empty) return fill == 0;
    return fill <= depth / 2;
  endfunction

endpackage

// File: rtl/ir_tx_fifo.sv
module ir_tx_fifo #(
  parameter int DW    = 17,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     fill
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [FW-1:0] cnt;
  logic          do_wr, do_rd;

  assign empty   = (cnt == '0);
  assign full    = (cnt == FW'(DEPTH));
  assign fill    = cnt;
  assign do_wr   = wr_en && !full && !flush;
  assign do_rd   = rd_en && !empty && !flush;
  assign rd_data = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ir_tx_tick.sv
module ir_tx_tick #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = run && (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !run)   cnt <= '0;
    else if (tick)              cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ir_tx_carrier.sv
module ir_tx_carrier #(
  parameter int PHW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           tick,
  input  logic [PHW-1:0] duty,
  output logic           carrier
);
  import ir_tx_pkg::*;

  logic [PHW-1:0] phase;

  assign carrier = carrier_on(int'(phase), int'(duty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (tick)    phase <= phase + 1'b1;
  end
endmodule

// File: rtl/ir_tx_seq.sv
module ir_tx_seq #(
  parameter int CW  = 16,
  parameter int HID = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          empty,
  input  logic [CW-1:0] q_count,
  input  logic          q_level,
  input  logic          tick,
  output logic          pop,
  output logic          active,
  output logic          level
);
  import ir_tx_pkg::*;

  localparam int REMW = CW + HID;

  seq_state_e      state;
  logic [REMW-1:0] remain;
  logic            last, load;

  // Duration in ticks: hidden low bits of the count read as all ones.
  function automatic logic [REMW-1:0] sym_len(input logic [CW-1:0] c);
    return {c, {HID{1'b1}}};
  endfunction

  assign active = (state == SEQ_RUN);
  assign last   = active && tick && (remain == REMW'(1));
  assign load   = en && !empty && (!active || last);
  assign pop    = load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      remain <= '0;
      level  <= 1'b0;
    end else if (!en) begin
      state  <= SEQ_IDLE;
    end else if (load) begin
      state  <= SEQ_RUN;
      remain <= sym_len(q_count);
      level  <= q_level;
    end else if (last) begin
      state  <= SEQ_IDLE;
    end else if (active && tick) begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/ir_tx_modulator.sv
module ir_tx_modulator #(
  parameter int CW    = 16,
  parameter int DIVW  = 16,
  parameter int DEPTH = 8,
  parameter int PHW   = 4,
  parameter int HID   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_en,
  input  logic            wr_en,
  input  logic [CW-1:0]   wr_count,
  input  logic            wr_level,
  input  logic [DIVW-1:0] div,
  input  logic [PHW-1:0]  duty,
  input  logic            mod_en,
  input  logic            pol_inv,
  input  logic            wm_empty,
  output logic            ir_out,
  output logic            busy,
  output logic            svc_req
);
  import ir_tx_pkg::*;

  localparam int DW = CW + 1;
  localparam int FW = $clog2(DEPTH) + 1;

  logic [DW-1:0] q_data;
  logic [FW-1:0] fifo_fill;
  logic          fifo_empty, fifo_full;
  logic          pop, tick, carrier;
  logic          sym_active, sym_level, burst_here;

  ir_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!tx_en),
    .wr_en(wr_en && tx_en), .wr_data({wr_level, wr_count}),
    .rd_en(pop), .rd_data(q_data),
    .empty(fifo_empty), .full(fifo_full), .fill(fifo_fill)
  );

  ir_tx_seq #(.CW(CW), .HID(HID)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .empty(fifo_empty),
    .q_count(q_data[CW-1:0]), .q_level(q_data[CW]),
    .tick(tick), .pop(pop), .active(sym_active), .level(sym_level)
  );

  ir_tx_tick #(.DIVW(DIVW)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(sym_active), .restart(pop),
    .div(div), .tick(tick)
  );

  ir_tx_carrier #(.PHW(PHW)) u_car (
    .clk(clk), .rst_n(rst_n), .restart(pop), .tick(tick),
    .duty(duty), .carrier(carrier)
  );

  assign burst_here = sym_level ^ pol_inv;
  assign busy       = sym_active;
  assign ir_out     = sym_active && (mod_en ? (burst_here && carrier) : sym_level);
  assign svc_req    = svc_needed(int'(fifo_fill), DEPTH, wm_empty);
endmodule

// File: rtl/ir_tx_checker.sv
module ir_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic wr_en,
  input logic mod_en,
  input logic pol_inv,
  input logic wm_empty,
  input logic ir_out,
  input logic busy,
  input logic svc_req,
  input logic fifo_empty,
  input logic fifo_full,
  input logic pop,
  input logic cur_level
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ir_out); // R8

  AST_SPACE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mod_en && !pol_inv && !cur_level) |-> !ir_out); // R3

  AST_MARK_SILENT_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mod_en && pol_inv && cur_level) |-> !ir_out); // R3

  AST_NOMOD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mod_en) |-> (ir_out == cur_level)); // R4

  AST_POP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && tx_en) |=> busy); // R5

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && wr_en && !pop && tx_en) |=> fifo_full); // R6

  AST_SVC_EMPTY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_empty && svc_req) |-> fifo_empty); // R7

  AST_DISABLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!busy && fifo_empty)); // R9
endmodule

bind ir_tx_modulator ir_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_en(wr_en),
  .mod_en(mod_en), .pol_inv(pol_inv), .wm_empty(wm_empty),
  .ir_out(ir_out), .busy(busy), .svc_req(svc_req),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full),
  .pop(pop), .cur_level(sym_level)
);

// File: tb/sim_ir_tx_modulator.sv
module sim_ir_tx_modulator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_count = '0;
  logic        wr_level = 1'b0;
  logic [15:0] div = '0;
  logic [3:0]  duty = '0;
  logic        mod_en = 1'b0;
  logic        pol_inv = 1'b0;
  logic        wm_empty = 1'b0;
  logic        ir_out, busy, svc_req;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ir_tx_modulator u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_en(wr_en),
    .wr_count(wr_count), .wr_level(wr_level), .div(div), .duty(duty),
    .mod_en(mod_en), .pol_inv(pol_inv), .wm_empty(wm_empty),
    .ir_out(ir_out), .busy(busy), .svc_req(svc_req)
  );

  typedef struct packed {
    logic [15:0] dv;
    logic [3:0]  dc;
    logic [15:0] cnt;
    logic        lvl;
    logic        md;
    logic        pl;
    logic [15:0] exp_busy;
    logic [15:0] exp_high;
  } vec_t;

  // busy = (4c+3)*(div+1); high = (div+1) * number of burst ticks whose phase <= duty
  localparam vec_t VECS [10] = '{
    '{16'd1, 4'd7,  16'd1, 1'b1, 1'b1, 1'b0, 16'd14, 16'd14},
    '{16'd0, 4'd3,  16'd4, 1'b1, 1'b1, 1'b0, 16'd19, 16'd7 },
    '{16'd2, 4'd3,  16'd2, 1'b0, 1'b1, 1'b0, 16'd33, 16'd0 },
    '{16'd2, 4'd3,  16'd2, 1'b0, 1'b1, 1'b1, 16'd33, 16'd12},
    '{16'd0, 4'd3,  16'd4, 1'b1, 1'b1, 1'b1, 16'd19, 16'd0 },
    '{16'd1, 4'd15, 16'd5, 1'b1, 1'b1, 1'b0, 16'd46, 16'd46},
    '{16'd0, 4'd0,  16'd8, 1'b1, 1'b1, 1'b0, 16'd35, 16'd3 },
    '{16'd3, 4'd5,  16'd0, 1'b1, 1'b0, 1'b0, 16'd12, 16'd12},
    '{16'd3, 4'd5,  16'd0, 1'b1, 1'b0, 1'b1, 16'd12, 16'd12},
    '{16'd1, 4'd0,  16'd3, 1'b0, 1'b0, 1'b0, 16'd30, 16'd0 }
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] c, input logic l);
    wr_en = 1'b1; wr_count = c; wr_level = l;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nb, nh;
    logic [12:0] pat;
    logic seen;

    // R10 reset state
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R10 busy at reset", busy, 0);
    check(ir_out == 1'b0, "R10 ir_out at reset", ir_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(svc_req == 1'b1, "R10 empty queue after reset", svc_req, 1);

    // vector table: R1 R2 R3 R4 R8
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      div = VECS[i].dv; duty = VECS[i].dc; mod_en = VECS[i].md; pol_inv = VECS[i].pl;
      push(VECS[i].cnt, VECS[i].lvl);
      @(negedge clk);
      wr_en = 1'b0;
      nb = 0; nh = 0;
      for (int k = 0; k < 3000; k++) begin
        if (busy) nb++;
        if (ir_out) nh++;
        if (!busy && nb > 0) break;
        @(negedge clk);
      end
      check(nb == int'(VECS[i].exp_busy), $sformatf("R1 vec%0d busy cycles", i), nb, int'(VECS[i].exp_busy));
      check(nh == int'(VECS[i].exp_high), $sformatf("R2 R3 R4 vec%0d high cycles", i), nh, int'(VECS[i].exp_high));
      check(ir_out == 1'b0, $sformatf("R8 vec%0d idle output", i), ir_out, 0);
    end

    // R5 order and gapless chaining, modulation off
    @(negedge clk);
    div = 0; mod_en = 1'b0; pol_inv = 1'b0;
    pat = '0; nb = 0;
    for (int k = 0; k < 20; k++) begin
      if (k == 0) push(16'd0, 1'b1);
      else if (k == 1) push(16'd1, 1'b0);
      else if (k == 2) push(16'd0, 1'b1);
      else wr_en = 1'b0;
      if (k >= 2 && k <= 14) pat[14 - k] = ir_out;
      if (busy) nb++;
      @(negedge clk);
    end
    check(pat == 13'b1110000000111, "R5 symbol order pattern", int'(pat), int'(13'b1110000000111));
    check(nb == 13, "R5 gapless busy", nb, 13);

    // R6 overflow and R7 thresholds
    div = 16'd9; wm_empty = 1'b0; nb = 0;
    for (int k = 0; k < 300; k++) begin
      if (k < 10) push(16'd0, 1'b1); else wr_en = 1'b0;
      if (busy) nb++;
      if (k == 21) begin
        check(svc_req == 1'b0, "R7 full queue half-mode", svc_req, 0);
        wm_empty = 1'b1; #1;
        check(svc_req == 1'b0, "R7 full queue empty-mode", svc_req, 0);
        wm_empty = 1'b0;
      end
      if (k == 131) begin
        check(svc_req == 1'b1, "R7 four queued half-mode", svc_req, 1);
        wm_empty = 1'b1; #1;
        check(svc_req == 1'b0, "R7 four queued empty-mode", svc_req, 0);
        wm_empty = 1'b0;
      end
      @(negedge clk);
    end
    check(nb == 270, "R6 one write dropped when full", nb, 270);
    wm_empty = 1'b1; #1;
    check(svc_req == 1'b1, "R7 drained empty-mode", svc_req, 1);
    wm_empty = 1'b0;

    // R9 disable stops at once and flushes
    @(negedge clk);
    mod_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      push(16'd10, 1'b1);
      @(negedge clk);
    end
    wr_en = 1'b0;
    repeat (20) @(negedge clk);
    check(busy == 1'b1, "R9 running before disable", busy, 1);
    tx_en = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R9 busy stops at once", busy, 0);
    check(ir_out == 1'b0, "R9 output stops at once", ir_out, 0);
    tx_en = 1'b1;
    seen = 1'b0;
    repeat (60) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
    end
    check(seen == 1'b0, "R9 queue flushed", seen, 0);

    // R9 writes while disabled are discarded
    tx_en = 1'b0;
    push(16'd0, 1'b1);
    @(negedge clk);
    wr_en = 1'b0; tx_en = 1'b1;
    seen = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
    end
    check(seen == 1'b0, "R9 write while disabled ignored", seen, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule